// File: doc/BRIEF.md
# Bank-Switched Shared Memory with Collision Voiding

This block is a word memory split into many independent single-port banks. Two request ports share it. Each request carries a bank number, a word address inside that bank, four byte lanes of nine bits, and a read or write command. A port can reach any bank. A given bank serves at most one port in a cycle, so the two ports work at full rate in parallel as long as they address different banks.

When both ports are enabled and name the same bank in the same cycle, the block does not pick a winner. Both accesses are voided: no write lands and no read returns data. Each port then raises its own collision flag one cycle later, so the requester can retry.

Both ports are sampled on the rising edge of one shared clock. Reads return their word one cycle after the request. Bank and word depths are package parameters. The defaults are 64 banks of 16 words each, so the default build stays small; the in-bank address can be widened to 11 bits.

Top module: `bsw_dpram`

## Requirements
- R1: A synchronous active-high reset forces `a_rvalid`, `b_rvalid`, `a_clash` and `b_clash` low on the following edge. Reset takes priority over any request present in the same cycle.
- R2: A read (`en`=1, `we`=0) issued in cycle N returns the addressed word on that port's `rdata`, with `rvalid`=1, after the edge that ends cycle N. The word reflects all writes accepted in earlier cycles, whichever port made them.
- R3: A write updates only the byte lanes whose `be` bit is 1. Lane k holds data bits [9k+8:9k]. The other lanes keep their earlier contents.
- R4: On a read, every lane whose `be` bit is 0 reads as zero on `rdata`.
- R5: When the two ports name different banks in the same cycle, both accesses complete, neither port's collision flag rises, and a write on one port does not disturb a read on the other.
- R6: When both ports are enabled with equal bank numbers, `a_clash` and `b_clash` are both 1 after that edge, and neither port's `rvalid` is set for that cycle.
- R7: During a collision, writes from both ports are discarded, and the addressed words keep their earlier contents.
- R8: A port with `en`=0 never causes a collision, even when its bank number equals the other port's.
- R9: Equal bank numbers collide even when the word addresses differ.
- R10: After any cycle that is not an accepted read (idle, write, or collision), that port's `rvalid` is 0 and its `rdata` is all zeros.
- R11: Words at the same word address in different banks are separate storage. Writing one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A request enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_bank | input | 6 | Port A bank number |
| a_addr | input | 4 | Port A word address within the bank |
| a_be | input | 4 | Port A byte-lane enables |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| a_clash | output | 1 | Port A access voided by a same-bank collision |
| b_en | input | 1 | Port B request enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_bank | input | 6 | Port B bank number |
| b_addr | input | 4 | Port B word address within the bank |
| b_be | input | 4 | Port B byte-lane enables |
| b_wdata | input | 36 | Port B write data |
| b_rdata | output | 36 | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |
| b_clash | output | 1 | Port B access voided by a same-bank collision |

## Verification
Every result of this block is due exactly one edge after its request: read data, `rvalid` and both collision flags all come from registers loaded at the edge that samples the request. Writes become visible to a read issued in the next cycle. The bench changes inputs only at falling edges, steps over one rising edge, and samples at the falling edge that follows. Every observation therefore falls in the cycle where that edge's results are stable. Voided writes and byte-lane effects are confirmed by a later read through the normal ports.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

    parameter int BANK_AW = 6;
    parameter int WORD_AW = 4;
    parameter int NBYTES  = 4;
    parameter int BYTE_W  = 9;

    localparam int NBANKS = 1 << BANK_AW;
    localparam int WORDS  = 1 << WORD_AW;
    localparam int DATA_W = NBYTES * BYTE_W;
    localparam int NPORTS = 2;

    typedef logic [BANK_AW-1:0] bank_t;
    typedef logic [WORD_AW-1:0] word_t;
    typedef logic [NBYTES-1:0]  lanes_t;
    typedef logic [DATA_W-1:0]  data_t;

    typedef struct packed {
        logic   en;
        logic   we;
        bank_t  bank;
        word_t  addr;
        lanes_t be;
        data_t  wdata;
    } port_req_t;

    typedef struct packed {
        logic   we;
        word_t  addr;
        lanes_t be;
        data_t  wdata;
    } bank_op_t;

    function automatic data_t lane_mask(input data_t d, input lanes_t be);
        data_t r;
        r = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (be[k]) r[k*BYTE_W +: BYTE_W] = d[k*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    function automatic bank_op_t to_op(input port_req_t r);
        bank_op_t o;
        o.we    = r.we;
        o.addr  = r.addr;
        o.be    = r.be;
        o.wdata = r.wdata;
        return o;
    endfunction

endpackage

// File: rtl/bsw_clash.sv
module bsw_clash
    import bsw_pkg::*;
(
    input  logic  en_a,
    input  logic  en_b,
    input  bank_t bank_a,
    input  bank_t bank_b,
    output logic  clash
);
    always_comb begin
        clash = en_a && en_b && (bank_a == bank_b);
    end
endmodule

// File: rtl/bsw_steer.sv
module bsw_steer
    import bsw_pkg::*;
(
    input  port_req_t         req,
    input  logic              clash,
    output logic [NBANKS-1:0] hit
);
    always_comb begin
        hit = '0;
        if (req.en && !clash) hit[req.bank] = 1'b1;
    end
endmodule

// File: rtl/bsw_bank.sv
module bsw_bank
    import bsw_pkg::*;
(
    input  logic     clk,
    input  logic     go,
    input  bank_op_t op,
    output data_t    rd_q
);
    data_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (go && op.we) begin
            for (int k = 0; k < NBYTES; k++) begin
                if (op.be[k]) mem[op.addr][k*BYTE_W +: BYTE_W] <= op.wdata[k*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (go && !op.we) rd_q <= mem[op.addr];
    end
endmodule

// File: rtl/bsw_dpram.sv
module bsw_dpram
    import bsw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 a_en,
    input  logic                 a_we,
    input  logic [BANK_AW-1:0]   a_bank,
    input  logic [WORD_AW-1:0]   a_addr,
    input  logic [NBYTES-1:0]    a_be,
    input  logic [DATA_W-1:0]    a_wdata,
    output logic [DATA_W-1:0]    a_rdata,
    output logic                 a_rvalid,
    output logic                 a_clash,
    input  logic                 b_en,
    input  logic                 b_we,
    input  logic [BANK_AW-1:0]   b_bank,
    input  logic [WORD_AW-1:0]   b_addr,
    input  logic [NBYTES-1:0]    b_be,
    input  logic [DATA_W-1:0]    b_wdata,
    output logic [DATA_W-1:0]    b_rdata,
    output logic                 b_rvalid,
    output logic                 b_clash
);
    port_req_t         req   [NPORTS];
    logic [NBANKS-1:0] hit   [NPORTS];
    data_t             bank_rd [NBANKS];
    logic              clash;

    logic   rv_q   [NPORTS];
    logic   cf_q   [NPORTS];
    bank_t  bank_q [NPORTS];
    lanes_t be_q   [NPORTS];
    data_t  rdata  [NPORTS];

    always_comb begin
        req[0] = '{en: a_en, we: a_we, bank: a_bank, addr: a_addr, be: a_be, wdata: a_wdata};
        req[1] = '{en: b_en, we: b_we, bank: b_bank, addr: b_addr, be: b_be, wdata: b_wdata};
    end

    bsw_clash u_clash (
        .en_a   (a_en),
        .en_b   (b_en),
        .bank_a (a_bank),
        .bank_b (b_bank),
        .clash  (clash)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        bsw_steer u_steer (
            .req   (req[p]),
            .clash (clash),
            .hit   (hit[p])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                rv_q[p] <= 1'b0;
                cf_q[p] <= 1'b0;
            end else begin
                rv_q[p] <= req[p].en && !req[p].we && !clash;
                cf_q[p] <= clash;
            end
        end

        always_ff @(posedge clk) begin
            if (req[p].en && !req[p].we) begin
                bank_q[p] <= req[p].bank;
                be_q[p]   <= req[p].be;
            end
        end

        always_comb begin
            rdata[p] = rv_q[p] ? lane_mask(bank_rd[bank_q[p]], be_q[p]) : '0;
        end
    end

    for (genvar k = 0; k < NBANKS; k++) begin : g_bank
        bank_op_t op;
        always_comb begin
            op = hit[0][k] ? to_op(req[0]) : to_op(req[1]);
        end
        bsw_bank u_bank (
            .clk  (clk),
            .go   (hit[0][k] | hit[1][k]),
            .op   (op),
            .rd_q (bank_rd[k])
        );
    end

    assign a_rdata  = rdata[0];
    assign b_rdata  = rdata[1];
    assign a_rvalid = rv_q[0];
    assign b_rvalid = rv_q[1];
    assign a_clash  = cf_q[0];
    assign b_clash  = cf_q[1];

    // R6
    clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && b_en && a_bank == b_bank) |=> (a_clash && b_clash));

    // R8
    clash_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(a_en && b_en) |=> (!a_clash && !b_clash));

    // R6
    clash_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        a_clash |-> (!a_rvalid && !b_rvalid));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!a_rvalid |-> a_rdata == '0) and (!b_rvalid |-> b_rdata == '0));

    // R5
    owner_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (hit[0] & hit[1]) == '0);

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (a_en && !a_we && !(b_en && a_bank == b_bank)) |=> a_rvalid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!a_rvalid && !b_rvalid && !a_clash && !b_clash));
endmodule

// File: tb/tb_bsw_dpram.sv
module tb_bsw_dpram;
    import bsw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // entry: {bank[6], addr[4], data[36]}
    localparam logic [45:0] VEC [NVEC] = '{
        {6'd0,  4'd0,  36'h123456789},
        {6'd1,  4'd0,  36'h9ABCDEF01},
        {6'd63, 4'd15, 36'hFFFFFFFFF},
        {6'd32, 4'd7,  36'h000000001},
        {6'd5,  4'd3,  36'h5A5A5A5A5},
        {6'd5,  4'd4,  36'hA5A5A5A5A},
        {6'd17, 4'd9,  36'h0F0F0F0F0},
        {6'd62, 4'd0,  36'h800000000}
    };

    logic clk = 1'b0;
    logic rst;
    logic a_en, a_we, b_en, b_we;
    logic [5:0]  a_bank, b_bank;
    logic [3:0]  a_addr, b_addr, a_be, b_be;
    logic [35:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic a_rvalid, a_clash, b_rvalid, b_clash;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsw_dpram dut (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_bank(a_bank), .a_addr(a_addr), .a_be(a_be),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_clash(a_clash),
        .b_en(b_en), .b_we(b_we), .b_bank(b_bank), .b_addr(b_addr), .b_be(b_be),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_clash(b_clash)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_a(input logic en, input logic we, input logic [5:0] bk,
                           input logic [3:0] ad, input logic [3:0] be, input logic [35:0] d);
        a_en = en; a_we = we; a_bank = bk; a_addr = ad; a_be = be; a_wdata = d;
    endtask

    task automatic drive_b(input logic en, input logic we, input logic [5:0] bk,
                           input logic [3:0] ad, input logic [3:0] be, input logic [35:0] d);
        b_en = en; b_we = we; b_bank = bk; b_addr = ad; b_be = be; b_wdata = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        drive_a(1'b0, 1'b0, 6'd0, 4'd0, 4'h0, '0);
        drive_b(1'b0, 1'b0, 6'd0, 4'd0, 4'h0, '0);
    endtask

    function automatic logic [35:0] lanes(input logic [35:0] d, input logic [3:0] be);
        logic [35:0] r = '0;
        for (int k = 0; k < 4; k++) if (be[k]) r[k*9 +: 9] = d[k*9 +: 9];
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive_a(1'b0, 1'b0, 6'd0, 4'd0, 4'h0, '0);
        drive_b(1'b0, 1'b0, 6'd0, 4'd0, 4'h0, '0);
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 a_rvalid", {35'd0, a_rvalid}, 36'd0);
        chk("R1 b_rvalid", {35'd0, b_rvalid}, 36'd0);
        chk("R1 clash", {34'd0, a_clash, b_clash}, 36'd0);

        // vector table: write through A, read back alternately through B and A (R2, R11)
        for (int i = 0; i < NVEC; i++) begin
            drive_a(1'b1, 1'b1, VEC[i][45:40], VEC[i][39:36], 4'hF, VEC[i][35:0]);
            step();
            chk("R10 write gives no rvalid", {35'd0, a_rvalid}, 36'd0);
        end
        for (int i = 0; i < NVEC; i++) begin
            if (i % 2 == 0) begin
                drive_b(1'b1, 1'b0, VEC[i][45:40], VEC[i][39:36], 4'hF, '0);
                step();
                chk("R2 R11 read via B", b_rdata, VEC[i][35:0]);
                chk("R2 b_rvalid", {35'd0, b_rvalid}, 36'd1);
            end else begin
                drive_a(1'b1, 1'b0, VEC[i][45:40], VEC[i][39:36], 4'hF, '0);
                step();
                chk("R2 R11 read via A", a_rdata, VEC[i][35:0]);
                chk("R2 a_rvalid", {35'd0, a_rvalid}, 36'd1);
            end
        end

        // R3 partial write: lanes 0 and 2 only
        drive_a(1'b1, 1'b1, 6'd10, 4'd2, 4'hF, 36'h000000000);
        step();
        drive_a(1'b1, 1'b1, 6'd10, 4'd2, 4'b0101, 36'hFFFFFFFFF);
        step();
        drive_a(1'b1, 1'b0, 6'd10, 4'd2, 4'hF, '0);
        step();
        chk("R3 lane write", a_rdata, lanes(36'hFFFFFFFFF, 4'b0101));

        // R4 lane-masked read of all-ones word, lane 1 only
        drive_b(1'b1, 1'b0, 6'd63, 4'd15, 4'b0010, '0);
        step();
        chk("R4 masked read", b_rdata, 36'h00003FE00);

        // R5 different banks at once: A writes, B reads
        drive_a(1'b1, 1'b1, 6'd20, 4'd1, 4'hF, 36'h13579BDF0);
        drive_b(1'b1, 1'b0, 6'd0, 4'd0, 4'hF, '0);
        step();
        chk("R5 B read beside A write", b_rdata, 36'h123456789);
        chk("R5 no clash", {34'd0, a_clash, b_clash}, 36'd0);
        drive_a(1'b1, 1'b0, 6'd20, 4'd1, 4'hF, '0);
        step();
        chk("R5 A write landed", a_rdata, 36'h13579BDF0);

        // R6 R7 both write same word of bank 5
        drive_a(1'b1, 1'b1, 6'd5, 4'd3, 4'hF, 36'h111111111);
        drive_b(1'b1, 1'b1, 6'd5, 4'd3, 4'hF, 36'h222222222);
        step();
        chk("R6 clash flags", {34'd0, a_clash, b_clash}, 36'd3);
        drive_a(1'b1, 1'b0, 6'd5, 4'd3, 4'hF, '0);
        step();
        chk("R7 word unchanged", a_rdata, 36'h5A5A5A5A5);
        chk("R7 clash cleared", {34'd0, a_clash, b_clash}, 36'd0);

        // R9 same bank, different words: A reads, B writes
        drive_a(1'b1, 1'b0, 6'd5, 4'd4, 4'hF, '0);
        drive_b(1'b1, 1'b1, 6'd5, 4'd3, 4'hF, 36'h333333333);
        step();
        chk("R9 clash on differing words", {34'd0, a_clash, b_clash}, 36'd3);
        chk("R6 voided read invalid", {35'd0, a_rvalid}, 36'd0);
        chk("R10 voided read zero", a_rdata, 36'd0);
        drive_b(1'b1, 1'b0, 6'd5, 4'd3, 4'hF, '0);
        step();
        chk("R7 R9 voided write dropped", b_rdata, 36'h5A5A5A5A5);

        // R8 same bank but B disabled
        drive_a(1'b1, 1'b0, 6'd5, 4'd4, 4'hF, '0);
        drive_b(1'b0, 1'b1, 6'd5, 4'd4, 4'hF, 36'h444444444);
        step();
        chk("R8 no clash", {34'd0, a_clash, b_clash}, 36'd0);
        chk("R8 read ok", a_rdata, 36'hA5A5A5A5A);

        // R10 idle cycle
        step();
        chk("R10 idle rvalid", {34'd0, a_rvalid, b_rvalid}, 36'd0);
        chk("R10 idle rdata", a_rdata | b_rdata, 36'd0);

        // R1 reset beats a read in the same cycle
        drive_a(1'b1, 1'b0, 6'd0, 4'd0, 4'hF, '0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 reset over read", {35'd0, a_rvalid}, 36'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule